// File: doc/BRIEF.md
# Load-Reserved / Store-Conditional Reservation Monitor

This block keeps one reservation for each hart of a multi-hart cluster and decides, for every store-conditional, whether it may write memory. A load-reserved event from a hart records the reservation for that hart: a valid bit, the aligned 8-byte granule and the mask of bytes the access covered. A later store-conditional from the same hart succeeds only if the reservation is still alive. It also has to match the reserved address and width, unless the policy input allows a mismatched pair to succeed.

Two sources feed the block. The first is the event port, which carries the memory instructions each hart issues, in program order for that hart. The second is the snoop port, which reports stores that harts commit to memory. A committed store from one hart cancels any other hart's reservation whose bytes it touches. Every store-conditional produces a registered result one cycle later: a success flag, a store-issue enable that only a success can raise, and the value for the destination register.

Top module: `resv_monitor`

## Requirements
- R1: An event with `evKind` = 1 (load-reserved) records a reservation for hart `evHart`. The granule is `evAddr[ADDR_W-1:3]`. The byte mask covers 2^`evSize` bytes (`evSize` 0..3 = 1, 2, 4, 8 bytes) starting at byte `evAddr[2:0]`. A store-conditional (`evKind` = 2) from that hart with the same granule and mask then succeeds. Every store-conditional raises `scDone` for exactly one cycle, in the cycle after its event.
- R2: Every load-reserved and every store-conditional first drops the issuing hart's reservation. A store-conditional therefore pairs only with the latest earlier load-reserved that has no other load-reserved or store-conditional between them, and a second store-conditional in a row fails.
- R3: `scStoreEn` is high in the result cycle of a successful store-conditional and low otherwise, so a failed store-conditional issues no store.
- R4: In a result cycle `scRdValue` is 0 on success and 1 on failure. It is 0 in all other cycles.
- R5: A snooped store (`snoopValid`) from hart `snoopHart` clears the reservation of every other hart whose granule matches and whose byte mask overlaps the store's byte mask. A store-conditional from that hart then fails.
- R6: A snooped store leaves a reservation intact when it comes from the reserving hart itself, or when its bytes do not overlap the reserved bytes (a different granule, or disjoint bytes within the same granule).
- R7: A snoop and an event in the same cycle are ordered snoop first. An overlapping snoop therefore fails a same-cycle store-conditional of another hart, and a reservation installed by a same-cycle load-reserved survives the snoop.
- R8: With `mismatchOk` = 1, a store-conditional succeeds whenever its hart's reservation is alive, whatever its address and size. With `mismatchOk` = 0 it also requires the same granule and mask, and it fails otherwise.
- R9: Plain store (`evKind` = 0) and AMO (`evKind` = 3) events on the event port change no reservation and raise no result.
- R10: Reset clears every reservation and all outputs, so a store-conditional issued right after reset fails.
- R11: Reservations of different harts are independent: events from one hart never change another hart's reservation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| mismatchOk | input | 1 | Policy: 1 lets a store-conditional succeed on a live reservation despite differing address or size |
| evValid | input | 1 | Event port valid |
| evKind | input | 2 | 0 store, 1 load-reserved, 2 store-conditional, 3 AMO |
| evHart | input | HART_W | Issuing hart |
| evAddr | input | ADDR_W | Byte address of the access, aligned to its size |
| evSize | input | 2 | log2 of the access size in bytes |
| snoopValid | input | 1 | A store has been committed to memory |
| snoopHart | input | HART_W | Hart that committed the store |
| snoopAddr | input | ADDR_W | Byte address of the committed store, aligned |
| snoopSize | input | 2 | log2 of the committed store size |
| scDone | output | 1 | Store-conditional result valid |
| scSuccess | output | 1 | Store-conditional succeeded |
| scStoreEn | output | 1 | Issue the store of a successful store-conditional |
| scRdValue | output | XLEN | Destination register value, 0 success / 1 failure |

## Verification
Directed sequences each isolate one rule. A matched pair against a back-to-back second store-conditional separates success from pairing. A load-reserved that replaces an earlier one shows that only the latest reservation counts. Overlapping, disjoint-byte, other-granule and own-hart snoops show exactly which stores cancel a reservation. Same-cycle snoop and event pairs fix the ordering between the two ports. Runs with `mismatchOk` set and cleared tell the two policies apart, and stores and AMOs on the event port show they change nothing. A long pseudo-random mix over a handful of overlapping addresses is then compared against a range-based behavioural model every cycle.

// File: rtl/resv_pkg.sv
`timescale 1ns/1ps
package resv_pkg;

  localparam int GRAN_BYTES = 8;
  localparam int OFF_W      = $clog2(GRAN_BYTES);

  typedef enum logic [1:0] {
    EV_STORE = 2'd0,
    EV_LR    = 2'd1,
    EV_SC    = 2'd2,
    EV_AMO   = 2'd3
  } evKind_e;

  // strobes from control to datapath
  typedef struct packed {
    logic takeLr;
    logic takeSc;
  } resStrobe_t;

  // byte lanes touched by an aligned access of 2**sz bytes at offset off
  function automatic logic [GRAN_BYTES-1:0] sizeMask(input logic [1:0] sz,
                                                     input logic [OFF_W-1:0] off);
    logic [GRAN_BYTES-1:0] base;
    for (int i = 0; i < GRAN_BYTES; i++) begin
      base[i] = (i < (1 << sz));
    end
    return base << off;
  endfunction

endpackage

// File: rtl/resv_ctrl.sv
`timescale 1ns/1ps
module resv_ctrl import resv_pkg::*; #(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            evValid,
  input  logic [1:0]      evKind,
  input  logic            scPass,
  output resStrobe_t      strobe,
  output logic            scDone,
  output logic            scSuccess,
  output logic            scStoreEn,
  output logic [XLEN-1:0] scRdValue
);

  always_comb begin
    strobe.takeLr = evValid && (evKind == EV_LR);
    strobe.takeSc = evValid && (evKind == EV_SC);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scDone    <= 1'b0;
      scSuccess <= 1'b0;
      scStoreEn <= 1'b0;
      scRdValue <= '0;
    end else begin
      scDone    <= strobe.takeSc;
      scSuccess <= strobe.takeSc && scPass;
      scStoreEn <= strobe.takeSc && scPass;
      // rd: 0 on success, 1 on failure, 0 when idle
      scRdValue <= (strobe.takeSc && !scPass) ? XLEN'(1) : '0;
    end
  end

endmodule

// File: rtl/resv_datapath.sv
`timescale 1ns/1ps
module resv_datapath import resv_pkg::*; #(
  parameter int  NUM_HARTS = 4,
  parameter int  ADDR_W    = 32,
  localparam int HART_W    = (NUM_HARTS > 1) ? $clog2(NUM_HARTS) : 1,
  localparam int LINE_W    = ADDR_W - OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  resStrobe_t        strobe,
  input  logic [HART_W-1:0] evHart,
  input  logic [ADDR_W-1:0] evAddr,
  input  logic [1:0]        evSize,
  input  logic              snoopValid,
  input  logic [HART_W-1:0] snoopHart,
  input  logic [ADDR_W-1:0] snoopAddr,
  input  logic [1:0]        snoopSize,
  input  logic              mismatchOk,
  output logic              scPass
);

  logic [LINE_W-1:0]     evLine, snLine;
  logic [GRAN_BYTES-1:0] evMask, snMask;
  logic [NUM_HARTS-1:0]  passVec;

  assign evLine = evAddr[ADDR_W-1:OFF_W];
  assign snLine = snoopAddr[ADDR_W-1:OFF_W];
  assign evMask = sizeMask(evSize, evAddr[OFF_W-1:0]);
  assign snMask = sizeMask(snoopSize, snoopAddr[OFF_W-1:0]);

  for (genvar g = 0; g < NUM_HARTS; g++) begin : g_hart
    logic                  resValid;
    logic [LINE_W-1:0]     resLine;
    logic [GRAN_BYTES-1:0] resMask;
    logic                  evHere, snoopKill, exactHit;

    assign evHere    = (evHart == HART_W'(g));
    // another hart's committed store over any reserved byte
    assign snoopKill = snoopValid && (snoopHart != HART_W'(g)) && resValid &&
                       (resLine == snLine) && |(resMask & snMask);
    assign exactHit  = (resLine == evLine) && (resMask == evMask);
    assign passVec[g] = resValid && !snoopKill && (mismatchOk || exactHit);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        resValid <= 1'b0;
        resLine  <= '0;
        resMask  <= '0;
      end else if (evHere && (strobe.takeLr || strobe.takeSc)) begin
        // event is ordered after a same-cycle snoop
        resValid <= strobe.takeLr;
        if (strobe.takeLr) begin
          resLine <= evLine;
          resMask <= evMask;
        end
      end else if (snoopKill) begin
        resValid <= 1'b0;
      end
    end
  end

  assign scPass = passVec[evHart];

endmodule

// File: rtl/resv_monitor.sv
`timescale 1ns/1ps
module resv_monitor import resv_pkg::*; #(
  parameter int  NUM_HARTS = 4,
  parameter int  ADDR_W    = 32,
  parameter int  XLEN      = 64,
  localparam int HART_W    = (NUM_HARTS > 1) ? $clog2(NUM_HARTS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mismatchOk,
  input  logic              evValid,
  input  logic [1:0]        evKind,
  input  logic [HART_W-1:0] evHart,
  input  logic [ADDR_W-1:0] evAddr,
  input  logic [1:0]        evSize,
  input  logic              snoopValid,
  input  logic [HART_W-1:0] snoopHart,
  input  logic [ADDR_W-1:0] snoopAddr,
  input  logic [1:0]        snoopSize,
  output logic              scDone,
  output logic              scSuccess,
  output logic              scStoreEn,
  output logic [XLEN-1:0]   scRdValue
);

  resStrobe_t strobe;
  logic       scPass;

  resv_ctrl #(.XLEN(XLEN)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .evValid(evValid), .evKind(evKind),
    .scPass(scPass), .strobe(strobe), .scDone(scDone),
    .scSuccess(scSuccess), .scStoreEn(scStoreEn), .scRdValue(scRdValue)
  );

  resv_datapath #(.NUM_HARTS(NUM_HARTS), .ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .evHart(evHart),
    .evAddr(evAddr), .evSize(evSize), .snoopValid(snoopValid),
    .snoopHart(snoopHart), .snoopAddr(snoopAddr), .snoopSize(snoopSize),
    .mismatchOk(mismatchOk), .scPass(scPass)
  );

endmodule

// File: rtl/resv_checker.sv
`timescale 1ns/1ps
module resv_checker import resv_pkg::*; #(
  parameter int  NUM_HARTS = 4,
  parameter int  XLEN      = 64,
  localparam int HART_W    = (NUM_HARTS > 1) ? $clog2(NUM_HARTS) : 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              evValid,
  input logic [1:0]        evKind,
  input logic [HART_W-1:0] evHart,
  input logic              scDone,
  input logic              scSuccess,
  input logic              scStoreEn,
  input logic [XLEN-1:0]   scRdValue
);

  assert_result_timing_R1: assert property (@(posedge clk) disable iff (!rst_n)
    scDone |-> $past(evValid && evKind == EV_SC));

  assert_back_to_back_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (evValid && evKind == EV_SC && $past(evValid && evKind == EV_SC) &&
     $past(evHart) == evHart) |=> !scSuccess);

  assert_no_store_on_fail_R3: assert property (@(posedge clk) disable iff (!rst_n)
    scStoreEn |-> (scDone && scSuccess));

  assert_rd_value_R4: assert property (@(posedge clk) disable iff (!rst_n)
    scDone |-> (scRdValue == (scSuccess ? XLEN'(0) : XLEN'(1))));

  assert_quiet_non_sc_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (evValid && evKind != EV_SC) |=> !scDone);

  assert_reset_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!scDone && !scStoreEn && scRdValue == '0));

endmodule

bind resv_monitor resv_checker #(.NUM_HARTS(NUM_HARTS), .XLEN(XLEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .evValid(evValid), .evKind(evKind),
  .evHart(evHart), .scDone(scDone), .scSuccess(scSuccess),
  .scStoreEn(scStoreEn), .scRdValue(scRdValue)
);

// File: tb/resv_monitor_tb.sv
`timescale 1ns/1ps
module resv_monitor_tb;

  localparam int NH = 4;
  localparam int AW = 32;
  localparam int XL = 64;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          mismatchOk = 1'b0;
  logic          evValid = 1'b0;
  logic [1:0]    evKind = '0;
  logic [1:0]    evHart = '0;
  logic [AW-1:0] evAddr = '0;
  logic [1:0]    evSize = '0;
  logic          snoopValid = 1'b0;
  logic [1:0]    snoopHart = '0;
  logic [AW-1:0] snoopAddr = '0;
  logic [1:0]    snoopSize = '0;
  logic          scDone, scSuccess, scStoreEn;
  logic [XL-1:0] scRdValue;

  int compared = 0;
  int mismatched = 0;

  // behavioural reference: reserved byte range per hart
  bit      refValid [NH];
  longint  refStart [NH];
  longint  refLen   [NH];

  always #4 clk = ~clk;

  resv_monitor #(.NUM_HARTS(NH), .ADDR_W(AW), .XLEN(XL)) u_dut (
    .clk(clk), .rst_n(rst_n), .mismatchOk(mismatchOk),
    .evValid(evValid), .evKind(evKind), .evHart(evHart), .evAddr(evAddr),
    .evSize(evSize), .snoopValid(snoopValid), .snoopHart(snoopHart),
    .snoopAddr(snoopAddr), .snoopSize(snoopSize), .scDone(scDone),
    .scSuccess(scSuccess), .scStoreEn(scStoreEn), .scRdValue(scRdValue)
  );

  function automatic bit overlaps(longint a, longint an, longint b, longint bn);
    return (a < b + bn) && (b < a + an);
  endfunction

  task automatic compare(string req, bit eDone, bit eSucc);
    logic [XL-1:0] eRd;
    eRd = (eDone && !eSucc) ? XL'(1) : XL'(0);
    compared++;
    if (scDone !== eDone || scSuccess !== eSucc || scStoreEn !== eSucc || scRdValue !== eRd) begin
      mismatched++;
      $display("FAIL %s: done=%0b succ=%0b storeEn=%0b rd=%0d expected done=%0b succ=%0b storeEn=%0b rd=%0d",
               req, scDone, scSuccess, scStoreEn, scRdValue, eDone, eSucc, eSucc, eRd);
    end
  endtask

  // one clock: drive at negedge, update model, check registered result next negedge
  task automatic cyc(string req, bit ev, int kind, int hart, longint addr, int sz,
                     bit sn, int snHart, longint snAddr, int snSz);
    bit eDone, eSucc;
    evValid = ev; evKind = kind[1:0]; evHart = hart[1:0];
    evAddr = AW'(addr); evSize = sz[1:0];
    snoopValid = sn; snoopHart = snHart[1:0];
    snoopAddr = AW'(snAddr); snoopSize = snSz[1:0];
    eDone = 0; eSucc = 0;
    if (sn) begin
      for (int h = 0; h < NH; h++)
        if (h != snHart && refValid[h] && overlaps(refStart[h], refLen[h], snAddr, 1 << snSz))
          refValid[h] = 0;
    end
    if (ev && kind == 1) begin
      refValid[hart] = 1; refStart[hart] = addr; refLen[hart] = 1 << sz;
    end else if (ev && kind == 2) begin
      eDone = 1;
      eSucc = refValid[hart] &&
              (mismatchOk || (refStart[hart] == addr && refLen[hart] == (1 << sz)));
      refValid[hart] = 0;
    end
    @(posedge clk);
    @(negedge clk);
    compare(req, eDone, eSucc);
  endtask

  task automatic lr(string r, int h, longint a, int s);  cyc(r, 1, 1, h, a, s, 0, 0, 0, 0); endtask
  task automatic sc(string r, int h, longint a, int s);  cyc(r, 1, 2, h, a, s, 0, 0, 0, 0); endtask
  task automatic st(string r, int h, longint a, int s);  cyc(r, 1, 0, h, a, s, 0, 0, 0, 0); endtask
  task automatic amo(string r, int h, longint a, int s); cyc(r, 1, 3, h, a, s, 0, 0, 0, 0); endtask
  task automatic snp(string r, int h, longint a, int s); cyc(r, 0, 0, 0, 0, 0, 1, h, a, s); endtask

  initial begin
    #(8 * 200000);
    mismatched++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    int unsigned seed;
    for (int h = 0; h < NH; h++) begin refValid[h] = 0; refStart[h] = 0; refLen[h] = 0; end
    repeat (3) @(negedge clk);
    compare("R10 reset outputs", 0, 0);
    rst_n = 1'b1;
    sc("R10 sc after reset", 0, 'h100, 2);

    lr("R1 lr", 0, 'h100, 2);
    sc("R1 matched sc", 0, 'h100, 2);
    sc("R2 second sc", 0, 'h100, 2);
    lr("R2 lr old", 1, 'h200, 3);
    lr("R2 lr new", 1, 'h300, 3);
    sc("R2 sc to replaced lr", 1, 'h200, 3);
    lr("R2 lr", 1, 'h300, 3);
    sc("R2 sc latest lr", 1, 'h300, 3);

    lr("R3 lr", 2, 'h40, 0);
    sc("R3 R4 sc other byte", 2, 'h41, 0);
    lr("R4 lr", 2, 'h40, 0);
    sc("R4 sc success", 2, 'h40, 0);

    lr("R5 lr", 0, 'h104, 2);
    snp("R5 overlapping snoop", 1, 'h106, 1);
    sc("R5 sc after kill", 0, 'h104, 2);
    lr("R5 lr", 3, 'h110, 1);
    snp("R5 dword snoop", 2, 'h110, 3);
    sc("R5 sc after dword kill", 3, 'h110, 1);

    lr("R6 lr", 0, 'h104, 2);
    snp("R6 own hart snoop", 0, 'h104, 2);
    snp("R6 disjoint bytes", 1, 'h100, 2);
    snp("R6 next granule", 2, 'h108, 3);
    sc("R6 sc survives", 0, 'h104, 2);

    lr("R7 lr", 2, 'h500, 3);
    cyc("R7 sc with same-cycle snoop", 1, 2, 2, 'h500, 3, 1, 3, 'h504, 0);
    cyc("R7 lr with same-cycle snoop", 1, 1, 3, 'h600, 2, 1, 0, 'h600, 2);
    sc("R7 sc after lr+snoop", 3, 'h600, 2);

    mismatchOk = 1'b1;
    lr("R8 lr", 0, 'h700, 2);
    sc("R8 mismatched sc allowed", 0, 'h704, 1);
    lr("R8 lr", 0, 'h700, 2);
    snp("R8 kill", 1, 'h700, 0);
    sc("R8 mismatched sc dead", 0, 'h800, 3);
    mismatchOk = 1'b0;
    lr("R8 lr", 0, 'h700, 2);
    sc("R8 mismatched sc refused", 0, 'h700, 1);

    lr("R9 lr", 1, 'h900, 2);
    st("R9 own store", 1, 'h900, 2);
    amo("R9 own amo", 1, 'h900, 2);
    st("R9 other store event", 2, 'h900, 2);
    amo("R9 other amo event", 0, 'h900, 3);
    sc("R9 sc survives", 1, 'h900, 2);

    lr("R11 lr h0", 0, 'hA00, 2);
    lr("R11 lr h1", 1, 'hB00, 2);
    sc("R11 sc h1", 1, 'hB00, 2);
    sc("R11 sc h0", 0, 'hA00, 2);

    seed = 32'h1234_5678;
    for (int i = 0; i < 600; i++) begin
      int k, h, s, o, sh, ss, so;
      bit ev, sn;
      longint a, sa;
      seed = seed * 1103515245 + 12345; ev = seed[20]; k = int'(seed[22:21]); h = int'(seed[24:23]);
      s = int'(seed[26:25]); o = int'(seed[29:27]);
      a = 'h1000 + longint'(seed[30]) * 8 + ((o >> s) << s);
      seed = seed * 1103515245 + 12345; sn = seed[20] & seed[21]; sh = int'(seed[23:22]);
      ss = int'(seed[25:24]); so = int'(seed[28:26]);
      sa = 'h1000 + longint'(seed[29]) * 8 + ((so >> ss) << ss);
      if (i % 150 == 0) mismatchOk = ~mismatchOk;
      cyc("R1 R2 R5 R7 R8 R11 random mix", ev, k, h, a, s, sn, sh, sa, ss);
    end

    evValid = 0; snoopValid = 0;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule